// File: doc/BRIEF.md
# Electronic Fuse Startup and Fault Sequencer

This block is the protection state machine of an electronic fuse. Analog comparators and the enable decoder give it digital flags: input voltage good, input over-voltage, output above its own undervoltage level, overcurrent at the limit, severe overcurrent at twice the limit, dropout above the flag threshold, thermal trip and thermal recovery, a shorted current-set pin and a reverse-current fault. From these flags it decides when the pass switch may conduct. It also tells the current regulator which startup multiplier applies, drives an active-low open-drain fault flag and reports a latched-off condition.

Every delay counts pulses of a `tick` input, which is nominally one pulse per microsecond. After power is qualified, the switch starts in a two-stage startup. The current limit is raised for a short initial interval. The startup window must end with the dropout cleared, or the switch latches off. At the end of startup the two mode straps are sampled once. They select one of three responses to overcurrent: latch off, retry after a fixed off time, or regulate forever. The retry off time is always thirty blanking intervals. Thermal trips and severe overloads follow rules that depend on the mode.

Top module: `efuse_seq`

## Requirements
- R1: Out of reset the switch is off. With enable high, the input above UVLO and not above OVLO, and the output below its level, the switch turns on only after DEB_TICKS consecutive ticks. If the input leaves that window earlier, the count starts again from zero. An input that drops below UVLO turns the switch off on the next clock.
- R2: If the output is already above its undervoltage level when the block is enabled, or when the input comes back out of OVLO, the switch turns on at the next clock without the debounce delay.
- R3: `ilim_sel` encodes the current-limit multiplier: 0 is 1x, 1 is 1.5x, 2 is 2x. It equals the MULT_SEL parameter for the first STI_TICKS ticks of each startup, and 0 at all other times.
- R4: Startup lasts STO_TICKS ticks. If the dropout flag is still high when that window ends, the switch latches off (`latched`=1). Only enable going low or the input dropping below UVLO clears the latch.
- R5: The straps are read once, when the startup window ends. The encoding is 00 latchoff, 01 autoretry, and 10 or 11 continuous. Strap changes after that point have no effect.
- R6: In latchoff and autoretry modes, an overcurrent held for BLANK_TICKS consecutive ticks turns the switch off. An overcurrent that clears earlier restarts the blanking count.
- R7: After a blanking expiry in autoretry mode, the switch stays off for 30 x BLANK_TICKS ticks and then runs a new startup. In latchoff mode it latches off as in R4.
- R8: In continuous mode, an overcurrent at the limit never turns the switch off.
- R9: A severe overcurrent turns the switch off on the next clock. Once the block is running, the switch comes back after SEV_TICKS ticks. In latchoff and autoretry modes, the off interval counts toward blanking, so an overload that lasts BLANK_TICKS ticks ends as in R6/R7.
- R10: A thermal trip turns the switch off. In latchoff mode the switch latches off. Otherwise the block waits for thermal recovery and then restarts with a new startup. The restart comes after 30 x BLANK_TICKS ticks in autoretry mode and after DEB_TICKS ticks in continuous mode or during startup.
- R11: `fault_n` is low out of reset. One clock after any of these inputs, it goes low: dropout high, reverse fault, thermal trip, input below UVLO, input above OVLO, or current-set short. It returns high one clock after all of them clear. An overcurrent alone does not pull it low.
- R12: A shorted current-set pin during debounce or startup turns the switch off. The switch stays off while the short lasts, and the block restarts from idle once the short is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| en | input | 1 | Combined enable, high to run |
| vin_uv_ok | input | 1 | Input above the UVLO threshold |
| vin_ov | input | 1 | Input above the OVLO threshold |
| vout_ok | input | 1 | Output above its undervoltage level |
| oc | input | 1 | Current at the programmed limit |
| oc_severe | input | 1 | Current above twice the limit |
| drop_hi | input | 1 | Switch dropout above the flag threshold |
| therm_hot | input | 1 | Die temperature above the shutdown level |
| therm_cool | input | 1 | Die temperature below the recovery level |
| iset_short | input | 1 | Current-set pin shorted to ground |
| rev_fault | input | 1 | Reverse-current protection tripped |
| mode_strap | input | 2 | Fault response straps, open reads as 1 |
| sw_on | output | 1 | Pass switch on |
| ilim_sel | output | 2 | Current-limit multiplier code |
| fault_n | output | 1 | Fault flag, active low |
| latched | output | 1 | Switch latched off |

## Verification
A wrong internal state shows up on `sw_on` or `latched` as an edge in the wrong cycle. Every timer boundary is checked on both sides: one sample just before the expected clock and one just after it. An off-by-one count, a blanking counter that fails to restart, or a strap read at the wrong moment therefore shows within one clock of the expected change. A mis-sampled mode stays hidden until the first overcurrent or thermal trip. For that reason each mode is driven into each kind of fault, and the response is compared against the mode that was strapped at the sampling instant.

// File: rtl/efuse_seq_pkg.sv
package efuse_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEB,
        ST_START,
        ST_RUN,
        ST_SEVW,
        ST_COOL,
        ST_WAIT,
        ST_SHORT,
        ST_LATCH
    } st_e;

    typedef enum logic [1:0] {
        MD_LATCH = 2'd0,
        MD_RETRY = 2'd1,
        MD_CONT  = 2'd2
    } mode_e;

    function automatic mode_e decode_strap(input logic [1:0] s);
        case (s)
            2'b00:   return MD_LATCH;
            2'b01:   return MD_RETRY;
            default: return MD_CONT;
        endcase
    endfunction

endpackage

// File: rtl/efuse_seq_blank.sv
module efuse_seq_blank #(
    parameter int LIM = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    output logic expire
);
    localparam int BW = $clog2(LIM + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    // Expiry fires on the LIM-th active tick in a row.
    assign expire = active && tick && (cnt_q >= BW'(LIM - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!active) begin
            cnt_d = '0;
        end else if (tick && cnt_q < BW'(LIM)) begin
            cnt_d = cnt_q + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r6_no_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));

endmodule

// File: rtl/efuse_seq_flag.sv
module efuse_seq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic drop_hi,
    input  logic rev_fault,
    input  logic therm_hot,
    input  logic therm_sd,
    input  logic vin_uv_ok,
    input  logic vin_ov,
    input  logic iset_short,
    output logic fault_n
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = drop_hi | rev_fault | therm_hot | therm_sd |
                 !vin_uv_ok | vin_ov | iset_short;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b1;
        else        flag_q <= flag_d;
    end

    assign fault_n = !flag_q;

    a_r11_rev_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rev_fault |=> !fault_n);
    a_r11_uv_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_uv_ok |=> !fault_n);

endmodule

// File: rtl/efuse_seq.sv
module efuse_seq
    import efuse_seq_pkg::*;
#(
    parameter int          DEB_TICKS   = 1500,
    parameter int          STI_TICKS   = 24000,
    parameter int          STO_TICKS   = 1200000,
    parameter int          BLANK_TICKS = 24000,
    parameter int          SEV_TICKS   = 420,
    parameter logic [1:0]  MULT_SEL    = 2'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       vin_uv_ok,
    input  logic       vin_ov,
    input  logic       vout_ok,
    input  logic       oc,
    input  logic       oc_severe,
    input  logic       drop_hi,
    input  logic       therm_hot,
    input  logic       therm_cool,
    input  logic       iset_short,
    input  logic       rev_fault,
    input  logic [1:0] mode_strap,
    output logic       sw_on,
    output logic [1:0] ilim_sel,
    output logic       fault_n,
    output logic       latched
);
    localparam int RETRY_TICKS = 30 * BLANK_TICKS;
    localparam int MAX_A = (STO_TICKS > RETRY_TICKS) ? STO_TICKS : RETRY_TICKS;
    localparam int MAX_B = (DEB_TICKS > SEV_TICKS) ? DEB_TICKS : SEV_TICKS;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_T + 1);

    typedef struct packed {
        st_e           st;
        mode_e         mode;
        logic [CW-1:0] cnt;
        logic [CW-1:0] tgt;
    } seq_t;

    seq_t q, d;
    logic pg, drop_out, blank_act, blank_exp;

    assign pg       = vin_uv_ok && !vin_ov;
    assign drop_out = !en || !pg;

    // Blanking runs only in timed modes, while overloaded or in a severe-off gap.
    assign blank_act = (q.mode != MD_CONT) &&
                       ((q.st == ST_RUN && (oc || oc_severe)) || q.st == ST_SEVW);

    efuse_seq_blank #(.LIM(BLANK_TICKS)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .active (blank_act),
        .expire (blank_exp)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                if (en && pg && !iset_short) begin
                    if (vout_ok) begin
                        d.st   = ST_START;
                        d.mode = MD_CONT;
                    end else begin
                        d.st = ST_DEB;
                    end
                end
            end
            ST_DEB: begin
                if (drop_out) begin
                    d.st = ST_IDLE;
                end else if (iset_short) begin
                    d.st = ST_SHORT;
                end else if (tick) begin
                    if (q.cnt == CW'(DEB_TICKS - 1)) begin
                        d.st   = ST_START;
                        d.cnt  = '0;
                        d.mode = MD_CONT;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_START: begin
                if (drop_out) begin
                    d.st = ST_IDLE;
                end else if (iset_short) begin
                    d.st = ST_SHORT;
                end else if (oc_severe) begin
                    d.st  = ST_WAIT;
                    d.cnt = '0;
                    d.tgt = CW'(SEV_TICKS);
                end else if (therm_hot) begin
                    d.st = ST_COOL;
                end else if (tick) begin
                    if (q.cnt == CW'(STO_TICKS - 1)) begin
                        d.cnt = '0;
                        if (drop_hi) begin
                            d.st = ST_LATCH;
                        end else begin
                            d.st   = ST_RUN;
                            d.mode = decode_strap(mode_strap);
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_RUN, ST_SEVW: begin
                if (drop_out) begin
                    d.st = ST_IDLE;
                end else if (blank_exp) begin
                    d.cnt = '0;
                    d.tgt = CW'(RETRY_TICKS);
                    d.st  = (q.mode == MD_LATCH) ? ST_LATCH : ST_WAIT;
                end else if (q.st == ST_RUN) begin
                    d.cnt = '0;
                    if (oc_severe) begin
                        d.st = ST_SEVW;
                    end else if (therm_hot) begin
                        d.st = (q.mode == MD_LATCH) ? ST_LATCH : ST_COOL;
                    end
                end else if (tick) begin
                    if (q.cnt == CW'(SEV_TICKS - 1)) begin
                        d.st  = ST_RUN;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_COOL: begin
                if (drop_out) begin
                    d.st = ST_IDLE;
                end else if (therm_cool) begin
                    d.st  = ST_WAIT;
                    d.cnt = '0;
                    d.tgt = (q.mode == MD_RETRY) ? CW'(RETRY_TICKS) : CW'(DEB_TICKS);
                end
            end
            ST_WAIT: begin
                if (drop_out) begin
                    d.st = ST_IDLE;
                end else if (tick) begin
                    if (q.cnt == q.tgt - CW'(1)) begin
                        d.st   = ST_START;
                        d.cnt  = '0;
                        d.mode = MD_CONT;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_SHORT: begin
                if (drop_out || !iset_short) d.st = ST_IDLE;
            end
            ST_LATCH: begin
                if (!en || !vin_uv_ok) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.mode <= MD_CONT;
            q.cnt  <= '0;
            q.tgt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign sw_on    = (q.st == ST_START) || (q.st == ST_RUN);
    assign latched  = (q.st == ST_LATCH);
    assign ilim_sel = (q.st == ST_START && q.cnt < CW'(STI_TICKS)) ? MULT_SEL : 2'd0;

    efuse_seq_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .drop_hi    (drop_hi),
        .rev_fault  (rev_fault),
        .therm_hot  (therm_hot),
        .therm_sd   (d.st == ST_COOL),
        .vin_uv_ok  (vin_uv_ok),
        .vin_ov     (vin_ov),
        .iset_short (iset_short),
        .fault_n    (fault_n)
    );

    a_r1_uv_drops_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_uv_ok |=> !sw_on);
    a_r9_severe_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_on && oc_severe) |=> !sw_on);
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && en && vin_uv_ok) |=> latched);
    a_r8_cont_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.mode == MD_CONT && en && pg && !oc_severe && !therm_hot)
        |=> sw_on);
    a_r3_boost_while_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_sel != 2'd0) |-> sw_on);

endmodule

// File: tb/efuse_seq_tb.sv
`timescale 1ns/1ps
module efuse_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic en, vin_uv_ok, vin_ov, vout_ok, oc, oc_severe, drop_hi;
    logic therm_hot, therm_cool, iset_short, rev_fault;
    logic [1:0] mode_strap;
    logic sw_on, fault_n, latched;
    logic [1:0] ilim_sel;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [3:0] M_SW = 4'b0001, M_LAT = 4'b0010, M_FL = 4'b0100, M_IL = 4'b1000;

    typedef struct {
        string      req;
        logic [3:0] m;
        logic       sw;
        logic       lat;
        logic       fln;
        logic [1:0] il;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    efuse_seq #(
        .DEB_TICKS(4), .STI_TICKS(3), .STO_TICKS(10),
        .BLANK_TICKS(4), .SEV_TICKS(3), .MULT_SEL(2'd2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
        .vin_uv_ok(vin_uv_ok), .vin_ov(vin_ov), .vout_ok(vout_ok),
        .oc(oc), .oc_severe(oc_severe), .drop_hi(drop_hi),
        .therm_hot(therm_hot), .therm_cool(therm_cool),
        .iset_short(iset_short), .rev_fault(rev_fault),
        .mode_strap(mode_strap), .sw_on(sw_on), .ilim_sel(ilim_sel),
        .fault_n(fault_n), .latched(latched)
    );

    // Monitor: compares queued expectations just after each falling edge.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.m[0]) begin
                n_tests++;
                if (sw_on !== e.sw) begin
                    n_fail++;
                    $display("FAIL %s sw_on actual %b expected %b", e.req, sw_on, e.sw);
                end
            end
            if (e.m[1]) begin
                n_tests++;
                if (latched !== e.lat) begin
                    n_fail++;
                    $display("FAIL %s latched actual %b expected %b", e.req, latched, e.lat);
                end
            end
            if (e.m[2]) begin
                n_tests++;
                if (fault_n !== e.fln) begin
                    n_fail++;
                    $display("FAIL %s fault_n actual %b expected %b", e.req, fault_n, e.fln);
                end
            end
            if (e.m[3]) begin
                n_tests++;
                if (ilim_sel !== e.il) begin
                    n_fail++;
                    $display("FAIL %s ilim_sel actual %0d expected %0d", e.req, ilim_sel, e.il);
                end
            end
        end
    end

    task automatic expect_at(input string r, input logic [3:0] m, input logic sw,
                             input logic lat, input logic fln, input logic [1:0] il);
        exp_t e;
        e.req = r; e.m = m; e.sw = sw; e.lat = lat; e.fln = fln; e.il = il;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        en = 0; vin_uv_ok = 0; vin_ov = 0; vout_ok = 0; oc = 0; oc_severe = 0;
        drop_hi = 0; therm_hot = 0; therm_cool = 0; iset_short = 0; rev_fault = 0;
        mode_strap = strap;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic fast_up();
        en = 1; vin_uv_ok = 1; vout_ok = 1;
    endtask

    task automatic flag_probe(input string r, input int which);
        case (which)
            0: vin_ov = 1;
            1: rev_fault = 1;
            2: iset_short = 1;
            3: drop_hi = 1;
            default: therm_hot = 1;
        endcase
        step(1);
        expect_at(r, M_FL, 0, 0, 0, 0);
        vin_ov = 0; rev_fault = 0; iset_short = 0; drop_hi = 0; therm_hot = 0;
        step(1);
        expect_at(r, M_FL, 0, 0, 1, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Reset state (R1, R11)
        do_reset(2'b11);
        expect_at("R1 reset", M_SW | M_LAT | M_FL | M_IL, 0, 0, 0, 0);

        // R1 debounce with restart, R3 boost window
        en = 1; vin_uv_ok = 1;
        step(2); vin_uv_ok = 0;
        step(1); expect_at("R11 uv flag", M_SW | M_FL, 0, 0, 0, 0);
        vin_uv_ok = 1;
        step(4); expect_at("R1 debounce not done", M_SW | M_FL, 0, 0, 1, 0);
        step(1); expect_at("R3 boost at start", M_SW | M_IL, 1, 0, 1, 2'd2);
        step(3); expect_at("R3 boost ended", M_SW | M_IL, 1, 0, 1, 2'd0);

        // R2 skip debounce at enable and at OVLO exit
        do_reset(2'b11);
        fast_up();
        step(1); expect_at("R2 enable skip", M_SW, 1, 0, 1, 0);
        vin_ov = 1;
        step(1); expect_at("R2 ovlo off", M_SW | M_FL, 0, 0, 0, 0);
        vin_ov = 0;
        step(1); expect_at("R2 ovlo exit skip", M_SW, 1, 0, 1, 0);

        // R4 startup timeout latch and clear by enable toggle
        do_reset(2'b11);
        fast_up(); drop_hi = 1;
        step(10); expect_at("R4 before timeout", M_SW | M_LAT, 1, 0, 0, 0);
        step(1);  expect_at("R4 latched", M_SW | M_LAT | M_FL, 0, 1, 0, 0);
        drop_hi = 0;
        step(2);  expect_at("R4 latch holds", M_SW | M_LAT | M_FL, 0, 1, 1, 0);
        en = 0;
        step(1);  expect_at("R4 latch cleared", M_LAT, 0, 0, 0, 0);
        en = 1;
        step(1);  expect_at("R4 restart", M_SW, 1, 0, 0, 0);

        // R6 blank restart, R7 autoretry timing (strap 01)
        do_reset(2'b01);
        fast_up();
        step(11); expect_at("R5 running", M_SW | M_IL, 1, 0, 0, 2'd0);
        oc = 1;
        step(3);  oc = 0; expect_at("R6 short overload", M_SW, 1, 0, 0, 0);
        step(2);  oc = 1;
        step(3);  expect_at("R6 blank not done", M_SW, 1, 0, 0, 0);
        step(1);  expect_at("R6 blank expiry", M_SW | M_LAT, 0, 0, 0, 0);
        oc = 0;
        step(119); expect_at("R7 retry wait", M_SW | M_LAT, 0, 0, 0, 0);
        step(1);   expect_at("R7 retry restart", M_SW | M_IL, 1, 0, 0, 2'd2);

        // R5 strap ignored after sampling, R7 latchoff hold, input cycle clears
        do_reset(2'b00);
        fast_up();
        step(11); mode_strap = 2'b11; oc = 1;
        step(3);  expect_at("R5 latchoff blank", M_SW, 1, 0, 0, 0);
        step(1);  expect_at("R5 strap ignored latch", M_SW | M_LAT, 0, 1, 0, 0);
        oc = 0;
        step(5);  expect_at("R7 latchoff holds", M_SW | M_LAT, 0, 1, 0, 0);
        vin_uv_ok = 0;
        step(1);  expect_at("R4 input cycle clears", M_LAT | M_FL, 0, 0, 0, 0);

        // R8 continuous (strap 10), R11 flag follows dropout
        do_reset(2'b10);
        fast_up();
        step(11); oc = 1; drop_hi = 1;
        step(1);  expect_at("R11 dropout flag", M_SW | M_FL, 1, 0, 0, 0);
        step(20); expect_at("R8 continuous on", M_SW | M_LAT, 1, 0, 0, 0);
        drop_hi = 0;
        step(1);  expect_at("R11 flag release", M_FL, 0, 0, 1, 0);

        // R9 severe in continuous
        do_reset(2'b11);
        fast_up();
        step(11); oc_severe = 1;
        step(1);  expect_at("R9 severe off", M_SW | M_LAT, 0, 0, 0, 0);
        oc_severe = 0;
        step(2);  expect_at("R9 severe wait", M_SW, 0, 0, 0, 0);
        step(1);  expect_at("R9 severe back", M_SW | M_IL, 1, 0, 0, 2'd0);

        // R9 long severe in latchoff
        do_reset(2'b00);
        fast_up();
        step(11); oc_severe = 1;
        step(3);  expect_at("R9 long severe off", M_SW | M_LAT, 0, 0, 0, 0);
        step(1);  expect_at("R9 long severe latch", M_LAT, 0, 1, 0, 0);

        // R10 thermal continuous
        do_reset(2'b11);
        fast_up();
        step(11); therm_hot = 1;
        step(1);  expect_at("R10 thermal off", M_SW | M_FL, 0, 0, 0, 0);
        step(3);  therm_hot = 0; therm_cool = 1;
        step(4);  expect_at("R10 cont cool wait", M_SW, 0, 0, 0, 0);
        step(1);  expect_at("R10 cont restart", M_SW | M_IL, 1, 0, 0, 2'd2);

        // R10 thermal autoretry
        do_reset(2'b01);
        fast_up();
        step(11); therm_hot = 1;
        step(4);  therm_hot = 0; therm_cool = 1;
        step(120); expect_at("R10 retry cool wait", M_SW, 0, 0, 0, 0);
        step(1);   expect_at("R10 retry restart", M_SW, 1, 0, 0, 0);

        // R10 thermal latchoff
        do_reset(2'b00);
        fast_up();
        step(11); therm_hot = 1;
        step(1);  expect_at("R10 latch thermal", M_SW | M_LAT, 0, 1, 0, 0);
        therm_hot = 0; therm_cool = 1;
        step(5);  expect_at("R10 latch stays", M_LAT, 0, 1, 0, 0);

        // R11 flag sources one at a time, overcurrent alone does not flag
        do_reset(2'b11);
        vin_uv_ok = 1;
        step(1); expect_at("R11 idle clear", M_FL, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) flag_probe("R11 source", i);
        oc = 1;
        step(2); expect_at("R11 oc alone", M_FL, 0, 0, 1, 0);
        oc = 0;

        // R12 current-set short during startup
        do_reset(2'b11);
        fast_up();
        step(3); iset_short = 1;
        step(1); expect_at("R12 short off", M_SW | M_FL, 0, 0, 0, 0);
        step(6); expect_at("R12 short held", M_SW, 0, 0, 0, 0);
        iset_short = 0;
        step(1); expect_at("R12 short idle", M_SW, 0, 0, 0, 0);
        step(1); expect_at("R12 short restart", M_SW, 1, 0, 0, 0);

        step(3);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule